// File: doc/BRIEF.md
# Interrupt Enable, Status and Vector Unit

This block turns four single-cycle event pulses into one device interrupt line. The four events are data available, status valid, locality change and command ready. Each event sets a sticky pending bit. The pending bit is set whether or not that source is enabled, and it stays set until software writes a 1 to it. An enable register holds one mask bit per source, a global gate bit and a two-bit trigger mode field. The interrupt pin is driven from the pending bits that are also enabled. Depending on the mode, the pin acts as an active-high level, an active-low level, a high pulse or a low pulse.

Software reaches four registers through a simple register port, using byte offsets inside the window. A write is one strobed cycle. A read returns data combinationally for the offset on the address lines. An 8-bit vector register holds whatever line number software stores in it. A read-only capability word reports which trigger modes and event sources the block supports. The producers of the events and the decode of the rest of the window belong to neighbouring logic.

Top module: `intr_ctrl_unit`

## Requirements
- R1: Reset state: the enable register reads 0x00000008 (level-low mode, every source masked, global gate off), the status and vector registers read 0, and the interrupt pin is high.
- R2: The enable register sits at offset 0x08. Bit 31 is the global gate, bits 4:3 are the trigger mode, and bits 0, 1, 2 and 7 are the per-source masks. All other bits read back 0.
- R3: While the global gate is 0, the pin sits at the idle level of the current mode on the following cycle. The idle level is 0 for modes 00 and 10, and 1 for modes 01 and 11.
- R4: The status register sits at offset 0x10. Data available is bit 0, status valid is bit 1, locality change is bit 2 and command ready is bit 7. An event pulse sets its bit at the clock edge that samples it, whatever the enables are. The bit then reads as set from the next cycle on.
- R5: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged. If an event pulse and a clearing write hit the same bit in the same cycle, the event wins and the bit stays set.
- R6: Trigger mode encoding: 00 is level high, 01 is level low, 10 is rising pulse, 11 is falling pulse.
- R7: In the level modes, the pin is active one cycle after a state in which the global gate is set and some bit is both pending and enabled. The pin returns to idle one cycle after that condition ends.
- R8: In the pulse modes, the pin is active for exactly one cycle, one cycle after any bit enters the set of enabled pending bits. At all other times it is idle.
- R9: The vector register sits at offset 0x0C. It stores wdata[7:0], and bits 31:8 read back 0.
- R10: The capability register sits at offset 0x14 and reads 0x000001FF. Bits 0, 1, 2 and 7 report the event sources. Bits 3 to 6 report level high, level low, rising edge and falling edge. Bit 8 reports a static burst count. Writes to it have no effect.
- R11: Any other offset reads 0, and a write to it changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_data_avail | input | 1 | Data-available event pulse |
| ev_sts_valid | input | 1 | Status-valid event pulse |
| ev_loc_change | input | 1 | Locality-change event pulse |
| ev_cmd_ready | input | 1 | Command-ready event pulse |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 12 | Byte offset inside the window |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| irq | output | 1 | Interrupt line |

## Verification
Register reads are combinational. The bench therefore sets the offset half a cycle before the clock edge and compares the read data about 1 ns later. A write or an event shows up in a read one cycle after the edge that samples it. The interrupt pin is registered from the pending, mask and mode state, so its expected value is computed at each edge from the bench model's state before that edge's update. It is compared at the following falling edge, which puts the pin one cycle behind the register state. Random traffic covers mode changes, masking and clears, and directed steps pin down the reset values, an event colliding with a clear, and writes to the capability and unmapped offsets.

// File: rtl/intr_pkg.sv
package intr_pkg;

  localparam int unsigned NUM_SRC    = 4;
  localparam int unsigned GLOBAL_BIT = 31;
  localparam int unsigned MODE_LSB   = 3;

  localparam logic [11:0] OFS_ENABLE = 12'h008;
  localparam logic [11:0] OFS_VECTOR = 12'h00C;
  localparam logic [11:0] OFS_STATUS = 12'h010;
  localparam logic [11:0] OFS_CAPS   = 12'h014;

  typedef enum logic [1:0] {
    TRIG_LVL_HI    = 2'b00,
    TRIG_LVL_LO    = 2'b01,
    TRIG_EDGE_RISE = 2'b10,
    TRIG_EDGE_FALL = 2'b11
  } trig_mode_e;

  typedef struct packed {
    logic               glob;
    trig_mode_e         mode;
    logic [NUM_SRC-1:0] src_en;
  } enable_t;

  // register bit that carries source i (neighbours decode these positions)
  function automatic int unsigned src_bit(int unsigned i);
    case (i)
      0:       return 0;
      1:       return 1;
      2:       return 2;
      default: return 7;
    endcase
  endfunction

endpackage

// File: rtl/intr_status.sv
module intr_status
  import intr_pkg::*;
#(
  parameter int unsigned N = NUM_SRC
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);

  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)          pend_o[g] <= 1'b0;
      else if (set_i[g])   pend_o[g] <= 1'b1;
      else if (clr_i[g])   pend_o[g] <= 1'b0;
    end
  end

endmodule

// File: rtl/intr_cfg.sv
module intr_cfg
  import intr_pkg::*;
#(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned VEC_W    = 8,
  parameter trig_mode_e  RST_MODE = TRIG_LVL_LO
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [31:0]        wdata,
  output enable_t            cfg_o,
  output logic [VEC_W-1:0]   vec_o,
  output logic [NUM_SRC-1:0] clr_o
);

  localparam logic [ADDR_W-1:0] A_EN  = ADDR_W'(OFS_ENABLE);
  localparam logic [ADDR_W-1:0] A_VEC = ADDR_W'(OFS_VECTOR);
  localparam logic [ADDR_W-1:0] A_ST  = ADDR_W'(OFS_STATUS);

  logic               wr_en_reg, wr_vec_reg, wr_st_reg;
  logic [NUM_SRC-1:0] src_field;
  logic               unused_wdata;

  assign wr_en_reg  = wr_en && (addr == A_EN);
  assign wr_vec_reg = wr_en && (addr == A_VEC);
  assign wr_st_reg  = wr_en && (addr == A_ST);

  always_comb begin
    for (int i = 0; i < NUM_SRC; i++) src_field[i] = wdata[src_bit(i)];
  end

  assign clr_o = wr_st_reg ? src_field : '0;
  assign unused_wdata = ^{wdata[30:8], wdata[6:5]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_o.glob   <= 1'b0;
      cfg_o.mode   <= RST_MODE;
      cfg_o.src_en <= '0;
    end else if (wr_en_reg) begin
      cfg_o.glob   <= wdata[GLOBAL_BIT];
      cfg_o.mode   <= trig_mode_e'(wdata[MODE_LSB +: 2]);
      cfg_o.src_en <= src_field;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          vec_o <= '0;
    else if (wr_vec_reg) vec_o <= wdata[VEC_W-1:0];
  end

endmodule

// File: rtl/intr_trigger.sv
module intr_trigger
  import intr_pkg::*;
#(
  parameter trig_mode_e RST_MODE = TRIG_LVL_LO
) (
  input  logic               clk,
  input  logic               rst_n,
  input  enable_t            cfg_i,
  input  logic [NUM_SRC-1:0] pend_i,
  output logic               irq_o
);

  logic [NUM_SRC-1:0] act, act_prev, fresh;
  logic               assert_now;
  logic               is_edge, is_low;

  assign act        = cfg_i.glob ? (pend_i & cfg_i.src_en) : '0;
  assign fresh      = act & ~act_prev;
  assign is_edge    = cfg_i.mode[1];
  assign is_low     = cfg_i.mode[0];
  assign assert_now = is_edge ? (|fresh) : (|act);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_prev <= '0;
      irq_o    <= RST_MODE[0];
    end else begin
      act_prev <= act;
      irq_o    <= is_low ? ~assert_now : assert_now;
    end
  end

endmodule

// File: rtl/intr_ctrl_unit.sv
module intr_ctrl_unit
  import intr_pkg::*;
#(
  parameter int unsigned ADDR_W       = 12,
  parameter int unsigned VEC_W        = 8,
  parameter bit          STATIC_BURST = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_data_avail,
  input  logic              ev_sts_valid,
  input  logic              ev_loc_change,
  input  logic              ev_cmd_ready,
  input  logic              reg_wr_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq
);

  localparam trig_mode_e RST_MODE = TRIG_LVL_LO;
  localparam logic [31:0] MODE_CAPS = 32'h0000_0078;
  localparam logic [31:0] BURST_CAP = {23'd0, STATIC_BURST, 8'd0};

  enable_t            cfg;
  logic [VEC_W-1:0]   vec;
  logic [NUM_SRC-1:0] ev_vec, clr_vec, pend;
  logic [31:0]        src_mask_word, en_word, st_word, cap_word;

  assign ev_vec = {ev_cmd_ready, ev_loc_change, ev_sts_valid, ev_data_avail};

  intr_cfg #(.ADDR_W(ADDR_W), .VEC_W(VEC_W), .RST_MODE(RST_MODE)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .addr(reg_addr),
    .wdata(reg_wdata), .cfg_o(cfg), .vec_o(vec), .clr_o(clr_vec)
  );

  intr_status #(.N(NUM_SRC)) u_status (
    .clk(clk), .rst_n(rst_n), .set_i(ev_vec), .clr_i(clr_vec), .pend_o(pend)
  );

  intr_trigger #(.RST_MODE(RST_MODE)) u_trig (
    .clk(clk), .rst_n(rst_n), .cfg_i(cfg), .pend_i(pend), .irq_o(irq)
  );

  always_comb begin
    src_mask_word = '0;
    en_word       = '0;
    st_word       = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      src_mask_word[src_bit(i)] = 1'b1;
      en_word[src_bit(i)]       = cfg.src_en[i];
      st_word[src_bit(i)]       = pend[i];
    end
    en_word[GLOBAL_BIT]       = cfg.glob;
    en_word[MODE_LSB +: 2]    = cfg.mode;
  end

  assign cap_word = src_mask_word | MODE_CAPS | BURST_CAP;

  always_comb begin
    if (reg_addr == ADDR_W'(OFS_ENABLE))      reg_rdata = en_word;
    else if (reg_addr == ADDR_W'(OFS_VECTOR)) reg_rdata = 32'(vec);
    else if (reg_addr == ADDR_W'(OFS_STATUS)) reg_rdata = st_word;
    else if (reg_addr == ADDR_W'(OFS_CAPS))   reg_rdata = cap_word;
    else                                      reg_rdata = '0;
  end

endmodule

// File: rtl/intr_ctrl_unit_chk.sv
module intr_ctrl_unit_chk #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned VEC_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        wlow,
  input logic [3:0]        ev,
  input logic              glob,
  input logic [1:0]        mode,
  input logic [3:0]        src_en,
  input logic [3:0]        pend,
  input logic [VEC_W-1:0]  vec,
  input logic [VEC_W-1:0]  wvec,
  input logic              irq
);

  logic [3:0] wmap, clr_now;
  logic       wr_st, wr_vec;

  assign wmap    = {wlow[7], wlow[2], wlow[1], wlow[0]};
  assign wr_st   = wr_en && (addr == ADDR_W'(12'h010));
  assign wr_vec  = wr_en && (addr == ADDR_W'(12'h00C));
  assign clr_now = wr_st ? wmap : 4'd0;

  a_r3_global_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !glob |=> (irq == $past(mode[0])));

  a_r4_event_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (|ev) |=> ((pend & $past(ev)) == $past(ev)));

  a_r5_clear_one: assert property (@(posedge clk) disable iff (!rst_n)
    wr_st |=> ((pend & $past(wmap & ~ev)) == 4'd0));

  a_r5_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (|pend) |=> ((($past(pend) & ~$past(clr_now)) & ~pend) == 4'd0));

  a_r7_level_high: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00) |=> (irq == $past(glob && |(pend & src_en))));

  a_r9_vector_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_vec |=> (vec == $past(wvec)));

endmodule

bind intr_ctrl_unit intr_ctrl_unit_chk #(.ADDR_W(ADDR_W), .VEC_W(VEC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .addr(reg_addr),
  .wlow(reg_wdata[7:0]), .ev(ev_vec), .glob(cfg.glob), .mode(cfg.mode),
  .src_en(cfg.src_en), .pend(pend), .vec(vec), .wvec(reg_wdata[VEC_W-1:0]),
  .irq(irq)
);

// File: tb/intr_ctrl_unit_test.sv
module intr_ctrl_unit_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  ev = '0;
  logic        wr = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wd = '0;
  logic [31:0] rdata;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;

  // bench model, built from the requirements
  logic       m_glob;
  logic [1:0] m_mode;   // R6: 00 lvl hi, 01 lvl lo, 10 rise, 11 fall
  logic [3:0] m_src, m_pend, m_prev;
  logic [7:0] m_vec;
  logic       m_irq;

  always #2 clk = ~clk;

  intr_ctrl_unit uut (
    .clk(clk), .rst_n(rst_n),
    .ev_data_avail(ev[0]), .ev_sts_valid(ev[1]),
    .ev_loc_change(ev[2]), .ev_cmd_ready(ev[3]),
    .reg_wr_en(wr), .reg_addr(addr), .reg_wdata(wd),
    .reg_rdata(rdata), .irq(irq)
  );

  function automatic logic [31:0] place(input logic [3:0] v);
    return {24'd0, v[3], 4'd0, v[2], v[1], v[0]};
  endfunction

  function automatic logic [31:0] model_read(input logic [11:0] a);
    case (a)
      12'h008: return place(m_src) | {m_glob, 23'd0, 3'd0, m_mode, 3'd0};
      12'h00C: return {24'd0, m_vec};
      12'h010: return place(m_pend);
      12'h014: return 32'h0000_01FF;
      default: return 32'd0;
    endcase
  endfunction

  function automatic string read_tag(input logic [11:0] a);
    case (a)
      12'h008: return "R2";
      12'h00C: return "R9";
      12'h010: return "R4";
      12'h014: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_glob = 1'b0; m_mode = 2'b01; m_src = '0; m_pend = '0;
    m_prev = '0;   m_vec = '0;     m_irq = 1'b1;
  endtask

  task automatic model_edge(input logic w, input logic [11:0] a,
                            input logic [31:0] d, input logic [3:0] e);
    logic [3:0] act, nw, clr;
    logic       asrt;
    act  = m_glob ? (m_pend & m_src) : 4'd0;
    nw   = act & ~m_prev;
    asrt = m_mode[1] ? (|nw) : (|act);
    m_irq  = m_mode[0] ? ~asrt : asrt;
    m_prev = act;
    clr = (w && a == 12'h010) ? {d[7], d[2], d[1], d[0]} : 4'd0;
    m_pend = e | (m_pend & ~clr);
    if (w && a == 12'h008) begin
      m_glob = d[31]; m_mode = d[4:3]; m_src = {d[7], d[2], d[1], d[0]};
    end
    if (w && a == 12'h00C) m_vec = d[7:0];
  endtask

  // one cycle: check pin, drive, check read, clock, update model
  task automatic cyc(input logic w, input logic [11:0] a,
                     input logic [31:0] d, input logic [3:0] e);
    @(negedge clk);
    chk(!m_glob ? "R3 irq" : (m_mode[1] ? "R8 irq" : "R7 irq"), 32'(irq), 32'(m_irq));
    wr = w; addr = a; wd = d; ev = e;
    #1;
    chk(read_tag(a), rdata, model_read(a));
    @(posedge clk);
    model_edge(w, a, d, e);
  endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] r;
    model_reset();
    r = $urandom(32'd20240611);
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset values
    @(negedge clk);
    chk("R1 irq", 32'(irq), 32'd1);
    addr = 12'h008; #1; chk("R1 enable", rdata, 32'h0000_0008);
    addr = 12'h010; #1; chk("R1 status", rdata, 32'd0);
    addr = 12'h00C; #1; chk("R1 vector", rdata, 32'd0);
    addr = 12'h014; #1; chk("R10 caps", rdata, 32'h0000_01FF);
    @(posedge clk);
    model_edge(1'b0, 12'h014, 32'd0, 4'd0);

    // R2 reserved bits drop; level high, all sources, global on
    cyc(1'b1, 12'h008, 32'hFFFF_FF67, 4'd0);
    cyc(1'b1, 12'h008, 32'h8000_0087, 4'd0);
    cyc(1'b0, 12'h010, 32'd0, 4'b0001);
    cyc(1'b0, 12'h010, 32'd0, 4'd0);
    cyc(1'b0, 12'h010, 32'd0, 4'd0);
    // R5 event and clear on the same bit: event wins
    cyc(1'b1, 12'h010, 32'h0000_0001, 4'b0001);
    cyc(1'b0, 12'h010, 32'd0, 4'd0);
    cyc(1'b1, 12'h010, 32'h0000_0087, 4'd0);
    cyc(1'b0, 12'h010, 32'd0, 4'd0);
    cyc(1'b0, 12'h010, 32'd0, 4'd0);
    // R10 and R11 writes ignored
    cyc(1'b1, 12'h014, 32'hFFFF_FFFF, 4'd0);
    cyc(1'b1, 12'h020, 32'hFFFF_FFFF, 4'd0);
    cyc(1'b0, 12'h014, 32'd0, 4'd0);
    cyc(1'b0, 12'h020, 32'd0, 4'd0);
    // R8 rising pulse mode, then falling
    cyc(1'b1, 12'h008, 32'h8000_0097, 4'd0);
    cyc(1'b0, 12'h010, 32'd0, 4'b1000);
    cyc(1'b0, 12'h010, 32'd0, 4'd0);
    cyc(1'b0, 12'h010, 32'd0, 4'd0);
    cyc(1'b1, 12'h008, 32'h8000_009F, 4'd0);
    cyc(1'b0, 12'h010, 32'd0, 4'b0100);
    cyc(1'b0, 12'h010, 32'd0, 4'd0);
    cyc(1'b0, 12'h010, 32'd0, 4'd0);

    for (int i = 0; i < 4000; i++) begin
      logic [11:0] a;
      logic [31:0] d;
      logic [3:0]  e;
      logic        w;
      case ($urandom_range(0, 5))
        0: a = 12'h008;
        1: a = 12'h00C;
        2, 3: a = 12'h010;
        4: a = 12'h014;
        default: a = 12'($urandom_range(0, 63) * 4);
      endcase
      d = $urandom();
      if (a == 12'h008 && $urandom_range(0, 3) != 0) d[31] = 1'b1;
      w = ($urandom_range(0, 9) < 3);
      e = ($urandom_range(0, 3) == 0) ? 4'($urandom()) : 4'd0;
      cyc(w, a, d, e);
    end

    @(negedge clk);
    chk("R7 irq final", 32'(irq), 32'(m_irq));
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule